// File: doc/BRIEF.md
# Nibble SP-Network Stream Decryptor

This block turns a stream of encrypted 16-bit words into plaintext words. Each encrypted word is built from two consecutive ROM bytes, with the first byte in bits 7:0. The plaintext word is emitted in the same byte order. The cipher is a feedback stream: two applications of a keyed substitution-permutation round produce each plaintext word. The first round's result becomes the whitening value for the next word. That whitening value drops back to zero after every block of sixteen words, and also on a restart pulse.

Words enter and leave through valid/ready handshakes. A word is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its plaintext is registered on that edge, so `out_valid` rises one cycle later. A result is consumed on an edge where `out_valid` and `out_ready` are both high.

`in_ready` is high whenever the output register is empty or is being drained in the same cycle. Under back-pressure (`out_valid` high, `out_ready` low), the held result stays unchanged and no new word is accepted.

The two subkeys and the restart pulse are plain control inputs. They are sampled on the edge where a word is accepted.

Top module: `nibble_stream_decryptor`

## Requirements
- R1: The unkeyed mix T splits its input into nibbles n0 = bits 3:0 through n3 = bits 15:12. It starts an accumulator a = n3. For j = 0,1,2,3 in turn, it sets a = a XOR S_j[n_j], then copies bit i of a into bit i of output nibble (j - i) mod 4. The tables are:
  - S0 = 9,8,2,11,1,14,5,15,12,6,0,3,7,13,10,4
  - S1 = 2,10,0,15,14,1,11,3,7,12,13,8,4,9,5,6
  - S2 = 4,11,3,8,7,2,15,13,1,5,14,9,6,12,0,10
  - S3 = 1,13,8,2,0,5,6,14,4,11,15,10,12,3,7,9
- R2: The keyed round is R(x,k) = T(x XOR k) XOR k.
- R3: For an accepted word e with feedback f, the new feedback is g = R(e XOR f, key1). The plaintext is f XOR R(g, key2). Bits 7:0 of both words hold the earlier byte.
- R4: A word counter advances on every accepted word. When a word completes a block of BLOCK_WORDS (default 16) words, both the counter and the feedback clear to zero, so word 16, word 32 and so on use zero feedback.
- R5: A restart pulse clears the feedback and the counter. A word accepted in the same cycle as a restart is decrypted with zero feedback as the first word of a new block.
- R6: A word accepted on a rising edge shows its plaintext with `out_valid` high right after that edge.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold steady. `in_ready` equals (not `out_valid`) or `out_ready`.
- R8: After reset, `out_valid` is low, `in_ready` is high, and the feedback and counter are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| restart | input | 1 | Synchronous pulse that starts a new transfer |
| key1 | input | 16 | Subkey for the feedback round |
| key2 | input | 16 | Subkey for the output round |
| in_valid | input | 1 | Encrypted word present |
| in_ready | output | 1 | Block can accept a word this cycle |
| in_data | input | 16 | Encrypted word, earlier byte in bits 7:0 |
| out_valid | output | 1 | Plaintext word present |
| out_ready | input | 1 | Consumer takes the plaintext this cycle |
| out_data | output | 16 | Plaintext word, earlier byte in bits 7:0 |

## Verification
The bench builds the block with the default BLOCK_WORDS of 16. This keeps two full block wraps within a run of 48 identical words, so the plaintext at words 0, 16 and 32 can be compared directly. A mix of random keys, random back-pressure and random restarts then drives restarts onto mid-block words and onto the same cycle as an accepted word. A software model of the tables and rounds scores every result.

// File: rtl/nsd_pkg.sv
package nsd_pkg;
  localparam int NIB_W  = 4;
  localparam int NIBS   = 4;
  localparam int WORD_W = NIB_W * NIBS;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [NIB_W-1:0]  nib_t;

  localparam nib_t SUB_TAB [NIBS][16] = '{
    '{4'd9, 4'd8, 4'd2, 4'd11, 4'd1, 4'd14, 4'd5, 4'd15,
      4'd12, 4'd6, 4'd0, 4'd3, 4'd7, 4'd13, 4'd10, 4'd4},
    '{4'd2, 4'd10, 4'd0, 4'd15, 4'd14, 4'd1, 4'd11, 4'd3,
      4'd7, 4'd12, 4'd13, 4'd8, 4'd4, 4'd9, 4'd5, 4'd6},
    '{4'd4, 4'd11, 4'd3, 4'd8, 4'd7, 4'd2, 4'd15, 4'd13,
      4'd1, 4'd5, 4'd14, 4'd9, 4'd6, 4'd12, 4'd0, 4'd10},
    '{4'd1, 4'd13, 4'd8, 4'd2, 4'd0, 4'd5, 4'd6, 4'd14,
      4'd4, 4'd11, 4'd15, 4'd10, 4'd12, 4'd3, 4'd7, 4'd9}
  };
endpackage

// File: rtl/nsd_mix.sv
// Unkeyed nibble mix: chained substitution followed by a bit-diagonal spread.
module nsd_mix
  import nsd_pkg::*;
(
  input  word_t x,
  output word_t y
);
  nib_t sub [NIBS];

  for (genvar j = 0; j < NIBS; j++) begin : g_sub
    assign sub[j] = SUB_TAB[j][x[j*NIB_W +: NIB_W]];
  end

  nib_t acc;
  always_comb begin
    acc = x[WORD_W-1 -: NIB_W];
    y   = '0;
    for (int j = 0; j < NIBS; j++) begin
      acc = acc ^ sub[j];
      for (int i = 0; i < NIB_W; i++) begin
        // output nibble (j - i) mod NIBS, bit i
        y[((j - i + NIBS) % NIBS) * NIB_W + i] = acc[i];
      end
    end
  end
endmodule

// File: rtl/nsd_round.sv
// Keyed round: key applied before and after the unkeyed mix.
module nsd_round
  import nsd_pkg::*;
(
  input  word_t din,
  input  word_t key,
  output word_t dout
);
  word_t mixed;

  nsd_mix u_mix (
    .x (din ^ key),
    .y (mixed)
  );

  assign dout = mixed ^ key;
endmodule

// File: rtl/nsd_state.sv
// Feedback register and block counter; restart takes effect on the word in the same cycle.
module nsd_state
  import nsd_pkg::*;
#(
  parameter int BLOCK_WORDS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic advance,
  input  word_t fb_next,
  output word_t fb_use,
  output word_t fb_q,
  output logic [((BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1)-1:0] cnt_q
);
  localparam int CNT_W = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLOCK_WORDS - 1);

  logic [CNT_W-1:0] cnt_use;

  assign fb_use  = restart ? '0 : fb_q;
  assign cnt_use = restart ? '0 : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_q  <= '0;
      cnt_q <= '0;
    end else if (advance) begin
      if (cnt_use == LAST) begin
        fb_q  <= '0;
        cnt_q <= '0;
      end else begin
        fb_q  <= fb_next;
        cnt_q <= cnt_use + 1'b1;
      end
    end else if (restart) begin
      fb_q  <= '0;
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/nibble_stream_decryptor.sv
module nibble_stream_decryptor
  import nsd_pkg::*;
#(
  parameter int BLOCK_WORDS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic [15:0] key1,
  input  logic [15:0] key2,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [15:0] out_data
);
  localparam int CNT_W = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1;

  logic             in_fire;
  word_t            fb_use, fb_q, fb_next, second;
  logic [CNT_W-1:0] cnt_q;

  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;

  nsd_round u_fb_round (
    .din  (in_data ^ fb_use),
    .key  (key1),
    .dout (fb_next)
  );

  nsd_round u_out_round (
    .din  (fb_next),
    .key  (key2),
    .dout (second)
  );

  nsd_state #(.BLOCK_WORDS(BLOCK_WORDS)) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .advance (in_fire),
    .fb_next (fb_next),
    .fb_use  (fb_use),
    .fb_q    (fb_q),
    .cnt_q   (cnt_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_fire) begin
      out_valid <= 1'b1;
      out_data  <= fb_use ^ second;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/nsd_checker.sv
module nsd_checker #(
  parameter int BLOCK_WORDS = 16,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             restart,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [15:0]      out_data,
  input logic [15:0]      fb_q,
  input logic [CNT_W-1:0] cnt_q
);
  logic fire;
  assign fire = in_valid && in_ready;

  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < BLOCK_WORDS);

  assert_block_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !restart && (32'(cnt_q) == BLOCK_WORDS - 1) |=> (cnt_q == '0) && (fb_q == '0));

  assert_restart_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart && !fire |=> (cnt_q == '0) && (fb_q == '0));

  assert_restart_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart && fire && (BLOCK_WORDS > 1) |=> (32'(cnt_q) == 1));

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_ready_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

bind nibble_stream_decryptor nsd_checker #(
  .BLOCK_WORDS (BLOCK_WORDS),
  .CNT_W       (CNT_W)
) u_nsd_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .restart   (restart),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .fb_q      (fb_q),
  .cnt_q     (cnt_q)
);

// File: tb/sim_nibble_stream_decryptor.sv
`timescale 1ns/1ps
module sim_nibble_stream_decryptor;
  localparam int BW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        restart = 1'b0;
  logic [15:0] key1 = '0, key2 = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;

  always #5 clk = ~clk;

  nibble_stream_decryptor #(.BLOCK_WORDS(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .restart(restart), .key1(key1), .key2(key2),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int checks = 0;
  int errors = 0;

  localparam logic [3:0] TAB [4][16] = '{
    '{9,8,2,11,1,14,5,15,12,6,0,3,7,13,10,4},
    '{2,10,0,15,14,1,11,3,7,12,13,8,4,9,5,6},
    '{4,11,3,8,7,2,15,13,1,5,14,9,6,12,0,10},
    '{1,13,8,2,0,5,6,14,4,11,15,10,12,3,7,9}
  };

  function automatic logic [15:0] t_ref(input logic [15:0] v);
    logic [3:0]  a;
    logic [15:0] r;
    a = v[15:12];
    r = '0;
    for (int j = 0; j < 4; j++) begin
      a ^= TAB[j][v[4*j +: 4]];
      for (int i = 0; i < 4; i++) r[((j - i) & 3) * 4 + i] = a[i];
    end
    return r;
  endfunction

  function automatic logic [15:0] r_ref(input logic [15:0] v, input logic [15:0] k);
    return t_ref(v ^ k) ^ k;
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard state
  logic [15:0] exp_q[$];
  logic [15:0] m_fb = '0;
  int          m_cnt = 0;
  logic [15:0] cap [0:1023];
  int          ncap = 0;

  // drive one cycle; model the word if it is accepted
  task automatic drive(input bit v, input logic [15:0] d, input bit rdy, input bit rs);
    logic [15:0] g, e;
    @(negedge clk);
    in_valid = v; in_data = d; out_ready = rdy; restart = rs;
    #1;
    if (rs) begin m_fb = '0; m_cnt = 0; end
    if (in_valid && in_ready) begin
      g = r_ref(d ^ m_fb, key1);
      e = m_fb ^ r_ref(g, key2);
      exp_q.push_back(e);
      m_cnt++;
      if (m_cnt == BW) begin m_cnt = 0; m_fb = '0; end
      else m_fb = g;
    end
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0 || out_valid) && n < 100) begin
      drive(1'b0, '0, 1'b1, 1'b0);
      n++;
    end
    drive(1'b0, '0, 1'b1, 1'b0);
  endtask

  // monitor
  initial begin
    logic [15:0] e;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R3 unexpected output", out_data, 16'h0);
        else begin
          e = exp_q.pop_front();
          check(out_data == e, "R1/R2/R3 plaintext", out_data, e);
        end
        if (ncap < 1024) cap[ncap] = out_data;
        ncap++;
      end
    end
  end

  // watchdog
  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] w [5];
    logic [15:0] held;
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid, "R8 out_valid after reset", {15'd0, out_valid}, 16'h0);
    check(in_ready, "R8 in_ready after reset", {15'd0, in_ready}, 16'h1);
    @(negedge clk);
    rst_n = 1'b1;

    // R4: 48 identical words; words 0, 16, 32 see zero feedback
    key1 = 16'h3a5c; key2 = 16'hc017;
    ncap = 0;
    for (int k = 0; k < 48; k++) drive(1'b1, 16'h1234, 1'b1, 1'b0);
    drain();
    check(cap[16] == cap[0], "R4 word16 matches word0", cap[16], cap[0]);
    check(cap[32] == cap[0], "R4 word32 matches word0", cap[32], cap[0]);
    check(cap[1] == cap[17], "R4 word17 matches word1", cap[17], cap[1]);

    // R5: restart mid-block replays the same outputs
    key1 = 16'h0f0f; key2 = 16'h9124;
    for (int k = 0; k < 5; k++) w[k] = 16'(k * 16'h1357 + 16'h0a0b);
    for (int k = 0; k < 7; k++) drive(1'b1, 16'(k * 77), 1'b1, 1'b0);
    drain();
    ncap = 0;
    drive(1'b0, '0, 1'b1, 1'b1);
    for (int k = 0; k < 5; k++) drive(1'b1, w[k], 1'b1, 1'b0);
    drive(1'b1, w[0], 1'b1, 1'b1);
    for (int k = 1; k < 5; k++) drive(1'b1, w[k], 1'b1, 1'b0);
    drain();
    for (int k = 0; k < 5; k++)
      check(cap[k + 5] == cap[k], "R5 replay after restart", cap[k + 5], cap[k]);

    // R6: latency of one cycle
    drive(1'b1, 16'hbeef, 1'b1, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(out_valid, "R6 out_valid one cycle after accept", {15'd0, out_valid}, 16'h1);
    drain();

    // R7: stall holds data and deasserts in_ready
    drive(1'b1, 16'h5a5a, 1'b0, 1'b0);
    drive(1'b1, 16'h6b6b, 1'b0, 1'b0);
    held = out_data;
    for (int k = 0; k < 3; k++) begin
      drive(1'b1, 16'h6b6b, 1'b0, 1'b0);
      check(out_valid && out_data == held, "R7 held output", out_data, held);
      check(!in_ready, "R7 in_ready low under stall", {15'd0, in_ready}, 16'h0);
    end
    drain();

    // random mix: keys, back-pressure, restarts
    for (int p = 0; p < 4; p++) begin
      key1 = 16'($urandom); key2 = 16'($urandom);
      for (int k = 0; k < 300; k++)
        drive($urandom_range(0, 9) < 8, 16'($urandom), $urandom_range(0, 9) < 7,
              $urandom_range(0, 99) < 4);
      drain();
    end
    check(exp_q.size() == 0, "R3 scoreboard empty", 16'(exp_q.size()), 16'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule